// File: doc/BRIEF.md
# Spiking Neuron Membrane Engine

This block models one hardware spiking neuron. An 8-bit membrane potential register works like a counter with several ways to move. It adds signed synaptic weights when input spikes arrive. On every prescale tick it steps back toward a configurable resting level at a constant slope. When it reaches a configurable threshold it fires. Several synapse lanes can present a spike in the same cycle, and their weights are summed before they are added.

Control is a two-state Moore machine with an operational state and a refractory state. A firing loads a preset after-spike potential, emits a one-cycle output spike and enters the refractory state. In that state the potential recovers toward rest at its own slope. The neuron returns to the operational state once the potential equals rest. While refractory, the neuron either ignores input spikes or adds them after attenuating them by an arithmetic right shift, depending on the selected mode. All configuration values are plain inputs sampled every cycle.

Top module: `spk_neuron_core`

## Requirements
- R1: While rst_n is low at a clock edge, that edge sets potential to cfg_rest, refractory to 0 (operational) and spike_out to 0.
- R2: In the operational state, each lane with syn_valid high adds its two's-complement weight from syn_weight (lane i at bits [8i+7:8i]) to the potential at the next edge. A positive weight raises the potential and a negative weight lowers it.
- R3: On an edge where tick is high, the potential left after adding the inputs moves toward cfg_rest by cfg_op_slope when operational. It stops exactly at rest and never crosses it. A slope of 0 leaves it unchanged.
- R4: All valid lanes of one cycle are summed before they are added. Inputs add on top of the current, still-deflected potential, with no reset to rest.
- R5: The potential saturates at 0 and at 255 and never wraps.
- R6: When refractory is 0 and potential >= cfg_thresh at an edge, that edge sets spike_out to 1, refractory to 1 and potential to cfg_after.
- R7: On a firing edge, the inputs and the tick of that cycle have no effect on the potential.
- R8: While refractory, a tick moves the potential toward cfg_rest by cfg_ref_slope. An edge that sees refractory=1 and potential == cfg_rest clears refractory, and the inputs of that cycle are still handled by the refractory rules.
- R9: With cfg_partial=0 (absolute mode), input spikes have no effect while refractory.
- R10: With cfg_partial=1 (partial mode), each valid lane's weight is shifted arithmetically right by cfg_atten_shift (0 to 3, rounding toward minus infinity) before summing while refractory.
- R11: spike_out is high for exactly one cycle per firing, and no firing starts while refractory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescale enable for one slope step |
| syn_valid | input | N_SYN | Per-lane input spike strobe |
| syn_weight | input | N_SYN*8 | Per-lane signed weight, packed lane 0 lowest |
| cfg_rest | input | 8 | Resting potential |
| cfg_thresh | input | 8 | Firing threshold |
| cfg_after | input | 8 | After-spike potential |
| cfg_op_slope | input | 4 | Leak step in the operational state |
| cfg_ref_slope | input | 4 | Recovery step in the refractory state |
| cfg_atten_shift | input | 2 | Right-shift amount for partial mode |
| cfg_partial | input | 1 | 1 = partial refractory, 0 = absolute |
| spike_out | output | 1 | One-cycle output spike |
| refractory | output | 1 | 1 = refractory state, 0 = operational |
| potential | output | 8 | Membrane potential |

## Verification
The firing decision and the arrival of input spikes can land on the same edge. So can a tick and the return from refractory at rest. The bench raises the potential above threshold and then, in the very next cycle, drives large inhibitory weights together with a tick. The firing must win: the potential becomes cfg_after, and the inputs leave no trace. For the return edge, the bench drives attenuated or absolute-mode inputs in the cycle where the potential sits at rest, and checks them against the refractory rules. A per-cycle arithmetic model in the bench judges potential, state and spike together through sweeps over slopes, weights and shift amounts.

// File: rtl/spk_pkg.sv
// Shared types for the spiking neuron engine.
// Assumes: nothing beyond a two-state controller.
package spk_pkg;
    typedef enum logic {
        ST_OPER = 1'b0,
        ST_REFR = 1'b1
    } spk_state_e;
endpackage

// File: rtl/spk_syn_merge.sv
// Synapse merge: sums the weights of all valid lanes in one cycle.
// While refractory, lanes are dropped (absolute mode) or shifted right
// arithmetically (partial mode). Assumes SUM_W is wide enough for N_SYN lanes.
module spk_syn_merge #(
    parameter int N_SYN = 2,
    parameter int WT_W  = 8,
    parameter int SH_W  = 2,
    parameter int SUM_W = WT_W + $clog2(N_SYN) + 1
) (
    input  logic                    refr,
    input  logic                    partial,
    input  logic [SH_W-1:0]         shift,
    input  logic [N_SYN-1:0]        valid,
    input  logic [N_SYN*WT_W-1:0]   weight,
    output logic signed [SUM_W-1:0] sum
);
    logic signed [SUM_W-1:0] acc [N_SYN+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < N_SYN; i++) begin : g_lane
        logic signed [WT_W-1:0] w_raw;
        logic signed [WT_W-1:0] w_shf;
        logic signed [WT_W-1:0] w_eff;

        assign w_raw = weight[i*WT_W +: WT_W];
        assign w_shf = w_raw >>> shift;

        // Per-lane effective weight under the current state and mode
        always_comb begin
            if (!valid[i])
                w_eff = '0;
            else if (!refr)
                w_eff = w_raw;
            else if (partial)
                w_eff = w_shf;
            else
                w_eff = '0;
        end

        assign acc[i+1] = acc[i] + {{(SUM_W-WT_W){w_eff[WT_W-1]}}, w_eff};
    end

    assign sum = acc[N_SYN];
endmodule

// File: rtl/spk_membrane.sv
// Membrane potential register: adds the merged input with saturation,
// then on a tick steps toward rest without crossing it. A firing loads
// the after-spike value. Assumes SLOPE_W <= POT_W.
module spk_membrane #(
    parameter int POT_W   = 8,
    parameter int SUM_W   = 10,
    parameter int SLOPE_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    load_after,
    input  logic signed [SUM_W-1:0] in_sum,
    input  logic [SLOPE_W-1:0]      slope,
    input  logic [POT_W-1:0]        rest,
    input  logic [POT_W-1:0]        after,
    output logic [POT_W-1:0]        pot
);
    localparam int EXT_W = ((POT_W > SUM_W) ? POT_W : SUM_W) + 2;
    localparam logic signed [EXT_W-1:0] MAX_EXT =
        $signed({{(EXT_W-POT_W){1'b0}}, {POT_W{1'b1}}});

    logic [POT_W-1:0]        pot_q;
    logic signed [EXT_W-1:0] raw;
    logic [POT_W-1:0]        p_in;
    logic [POT_W-1:0]        p_lk;
    logic [POT_W-1:0]        step;

    assign raw  = $signed({{(EXT_W-POT_W){1'b0}}, pot_q})
                + {{(EXT_W-SUM_W){in_sum[SUM_W-1]}}, in_sum};
    assign step = {{(POT_W-SLOPE_W){1'b0}}, slope};

    // Clamp the sum of potential and input into the unsigned range
    always_comb begin
        if (raw[EXT_W-1])
            p_in = '0;
        else if (raw > MAX_EXT)
            p_in = '1;
        else
            p_in = raw[POT_W-1:0];
    end

    // One slope step toward rest, stopping at rest
    always_comb begin
        if (p_in > rest)
            p_lk = ((p_in - rest) > step) ? (p_in - step) : rest;
        else if (p_in < rest)
            p_lk = ((rest - p_in) > step) ? (p_in + step) : rest;
        else
            p_lk = p_in;
    end

    // Potential register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            pot_q <= rest;
        else if (load_after)
            pot_q <= after;
        else
            pot_q <= tick ? p_lk : p_in;
    end

    assign pot = pot_q;

    // R3
    leak_no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sum == 0 && tick && !load_after && pot_q > rest && slope != 0)
        |=> (pot_q >= $past(rest) && pot_q < $past(pot_q)));

    // R5
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_after && !tick && in_sum < 0 && {1'b0, pot_q} < -in_sum)
        |=> (pot_q == '0));
endmodule

// File: rtl/spk_ctrl.sv
// Two-state Moore controller: decides firing from the registered
// potential, raises a one-cycle spike and returns to operation at rest.
module spk_ctrl #(
    parameter int POT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POT_W-1:0] pot,
    input  logic [POT_W-1:0] thresh,
    input  logic [POT_W-1:0] rest,
    output logic             load_after,
    output logic             in_refr,
    output logic             spike
);
    import spk_pkg::*;

    spk_state_e state_q;
    logic       spike_q;

    assign load_after = (state_q == ST_OPER) && (pot >= thresh);

    // State and spike register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPER;
            spike_q <= 1'b0;
        end else begin
            spike_q <= load_after;
            case (state_q)
                ST_OPER: if (load_after) state_q <= ST_REFR;
                ST_REFR: if (pot == rest) state_q <= ST_OPER;
                default: state_q <= ST_OPER;
            endcase
        end
    end

    assign in_refr = (state_q == ST_REFR);
    assign spike   = spike_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_OPER && !spike_q));

    // R11
    spike_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |=> !spike_q);

    // R6
    spike_enters_refr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |-> (state_q == ST_REFR));
endmodule

// File: rtl/spk_neuron_core.sv
// Top of the spiking neuron: merges synapse lanes, updates the membrane
// and runs the operational/refractory controller. Configuration inputs
// are used combinationally every cycle.
module spk_neuron_core #(
    parameter int N_SYN   = 2,
    parameter int WT_W    = 8,
    parameter int POT_W   = 8,
    parameter int SLOPE_W = 4,
    parameter int SH_W    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [N_SYN-1:0]      syn_valid,
    input  logic [N_SYN*WT_W-1:0] syn_weight,
    input  logic [POT_W-1:0]      cfg_rest,
    input  logic [POT_W-1:0]      cfg_thresh,
    input  logic [POT_W-1:0]      cfg_after,
    input  logic [SLOPE_W-1:0]    cfg_op_slope,
    input  logic [SLOPE_W-1:0]    cfg_ref_slope,
    input  logic [SH_W-1:0]       cfg_atten_shift,
    input  logic                  cfg_partial,
    output logic                  spike_out,
    output logic                  refractory,
    output logic [POT_W-1:0]      potential
);
    localparam int SUM_W = WT_W + $clog2(N_SYN) + 1;

    logic                    load_after;
    logic                    in_refr;
    logic signed [SUM_W-1:0] in_sum;
    logic [SLOPE_W-1:0]      slope_sel;
    logic [POT_W-1:0]        pot;

    assign slope_sel = in_refr ? cfg_ref_slope : cfg_op_slope;

    spk_syn_merge #(.N_SYN(N_SYN), .WT_W(WT_W), .SH_W(SH_W), .SUM_W(SUM_W)) u_merge (
        .refr    (in_refr),
        .partial (cfg_partial),
        .shift   (cfg_atten_shift),
        .valid   (syn_valid),
        .weight  (syn_weight),
        .sum     (in_sum)
    );

    spk_membrane #(.POT_W(POT_W), .SUM_W(SUM_W), .SLOPE_W(SLOPE_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_after (load_after),
        .in_sum     (in_sum),
        .slope      (slope_sel),
        .rest       (cfg_rest),
        .after      (cfg_after),
        .pot        (pot)
    );

    spk_ctrl #(.POT_W(POT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pot        (pot),
        .thresh     (cfg_thresh),
        .rest       (cfg_rest),
        .load_after (load_after),
        .in_refr    (in_refr),
        .spike      (spike_out)
    );

    assign refractory = in_refr;
    assign potential  = pot;

    // R6 R7
    fire_loads_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!refractory && potential >= cfg_thresh)
        |=> (spike_out && refractory && potential == $past(cfg_after)));

    // R9
    absolute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refractory && !cfg_partial && !tick) |=> (potential == $past(potential)));

    // R8
    recover_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refractory && potential == cfg_rest) |=> !refractory);
endmodule

// File: tb/spk_neuron_core_tb.sv
// Self-checking bench: a per-cycle arithmetic model built from the
// requirements is compared with all outputs after every edge.
module spk_neuron_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] syn_valid = '0;
    logic [7:0] w0 = '0, w1 = '0;
    logic [7:0] cfg_rest = 8'd100, cfg_thresh = 8'd200, cfg_after = 8'd60;
    logic [3:0] cfg_op_slope = 4'd1, cfg_ref_slope = 4'd1;
    logic [1:0] cfg_atten_shift = '0;
    logic       cfg_partial = 1'b0;
    logic       spike_out, refractory;
    logic [7:0] potential;

    int checks = 0, errors = 0;
    int m_pot = 0;
    bit m_ref = 0, m_fire = 0;

    always #5 clk = ~clk;

    spk_neuron_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .syn_valid(syn_valid),
        .syn_weight({w1, w0}), .cfg_rest(cfg_rest), .cfg_thresh(cfg_thresh),
        .cfg_after(cfg_after), .cfg_op_slope(cfg_op_slope),
        .cfg_ref_slope(cfg_ref_slope), .cfg_atten_shift(cfg_atten_shift),
        .cfg_partial(cfg_partial), .spike_out(spike_out),
        .refractory(refractory), .potential(potential)
    );

    function automatic int sat(input int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    function automatic int toward(input int p, input int r, input int s);
        if (p > r) return (p - r > s) ? p - s : r;
        if (p < r) return (r - p > s) ? p + s : r;
        return p;
    endfunction

    function automatic int eff(input bit v, input int w);
        if (!v) return 0;
        if (!m_ref) return w;
        if (cfg_partial) return w >>> cfg_atten_shift;
        return 0;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (potential !== m_pot[7:0] || refractory !== m_ref || spike_out !== m_fire) begin
            errors++;
            $display("FAIL %s pot/ref/spike got %0d/%0b/%0b exp %0d/%0b/%0b",
                     tag, potential, refractory, spike_out, m_pot, m_ref, m_fire);
        end
    endtask

    // One cycle: drive at negedge, model the edge, sample at next negedge
    task automatic cyc(input string tag, input bit v0, input int a0,
                       input bit v1, input int a1, input bit tk);
        int p;
        syn_valid = {v1, v0};
        w0 = a0[7:0];
        w1 = a1[7:0];
        tick = tk;
        if (!m_ref && m_pot >= cfg_thresh) begin
            m_fire = 1; m_ref = 1; m_pot = cfg_after;
        end else begin
            p = sat(m_pot + eff(v0, $signed(w0)) + eff(v1, $signed(w1)));
            if (tk) p = toward(p, cfg_rest, m_ref ? cfg_ref_slope : cfg_op_slope);
            if (m_ref && m_pot == cfg_rest) m_ref = 0;
            m_fire = 0;
            m_pot = p;
        end
        @(posedge clk);
        @(negedge clk);
        syn_valid = '0;
        tick = 1'b0;
        compare(tag);
    endtask

    task automatic settle(input string tag);
        cfg_op_slope = 4'd9;
        cfg_ref_slope = 4'd9;
        for (int i = 0; i < 300; i++) begin
            if (!m_ref && !m_fire && m_pot == cfg_rest) break;
            cyc(tag, 0, 0, 0, 0, 1);
        end
    endtask

    task automatic make_fire(input string tag);
        for (int i = 0; i < 10; i++) begin
            if (m_fire) break;
            cyc(tag, !m_ref, 127, 0, 0, 0);
        end
    endtask

    initial begin
        #(150000 * 10);
        errors++;
        $display("FAIL watchdog expired got timeout exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pot = 100; m_ref = 0; m_fire = 0;
        compare("R1");

        // R2: single-lane weight sweep, no leak
        cfg_thresh = 8'd250;
        for (int w = -128; w <= 127; w += 5) begin
            cyc("R2", 1, w, 0, 0, 0);
            settle("R2");
        end

        // R4: parallel lanes summed, then stacked on the deflection
        for (int a = -40; a <= 40; a += 20)
            for (int b = -40; b <= 40; b += 20) begin
                cyc("R4", 1, a, 1, b, 0);
                cyc("R4", 0, 0, 1, a, 0);
                settle("R4");
            end

        // R3: leak at every slope 0..9 from above and below rest
        for (int s = 0; s <= 9; s++) begin
            cfg_op_slope = s[3:0];
            cyc("R3", 1, 57, 0, 0, 1);
            for (int i = 0; i < 20; i++) cyc("R3", 0, 0, 0, 0, 1);
            cfg_op_slope = s[3:0];
            cyc("R3", 1, -63, 0, 0, 1);
            for (int i = 0; i < 20; i++) cyc("R3", 0, 0, 0, 0, 1);
            settle("R3");
        end

        // R5: saturation at both ends
        cfg_rest = 8'd10;
        settle("R5");
        cyc("R5", 1, -128, 1, -128, 0);
        cyc("R5", 1, -1, 0, 0, 0);
        cfg_rest = 8'd200; cfg_thresh = 8'd255;
        settle("R5");
        cyc("R5", 1, 127, 1, 127, 0);
        cyc("R6", 0, 0, 0, 0, 0);
        settle("R5");

        // R6 R11: threshold sweep, firing edge and single-cycle spike
        cfg_rest = 8'd100; cfg_after = 8'd60;
        for (int t = 110; t <= 140; t += 6) begin
            cfg_thresh = t[7:0];
            settle("R6");
            cyc("R6", 1, t - 100, 0, 0, 0);
            cyc("R6", 0, 0, 0, 0, 0);
            cyc("R11", 1, 127, 1, 127, 0);
            cyc("R11", 0, 0, 0, 0, 0);
        end

        // R7: inputs and tick on the firing edge are dropped
        cfg_thresh = 8'd120;
        settle("R7");
        cyc("R7", 1, 30, 0, 0, 0);
        cfg_op_slope = 4'd9;
        cyc("R7", 1, -100, 1, -100, 1);
        cyc("R7", 0, 0, 0, 0, 0);

        // R8: recovery at each refractory slope, after-spike below and above rest
        for (int s = 1; s <= 9; s++) begin
            for (int up = 0; up < 2; up++) begin
                cfg_after = up ? 8'd180 : 8'd40;
                cfg_thresh = 8'd120;
                settle("R8");
                cfg_ref_slope = s[3:0];
                make_fire("R8");
                for (int i = 0; i < 100; i++) begin
                    if (!m_ref) break;
                    cyc("R8", 0, 0, 0, 0, 1);
                end
                cyc("R8", 0, 0, 0, 0, 0);
            end
        end

        // R9: absolute mode ignores inputs, also on the return edge at rest
        cfg_partial = 1'b0; cfg_after = 8'd70; cfg_ref_slope = 4'd5;
        settle("R9");
        make_fire("R9");
        for (int w = -120; w <= 120; w += 40) cyc("R9", 1, w, 1, -w / 2, 0);
        for (int i = 0; i < 12; i++) cyc("R9", 1, 90, 1, 90, 1);

        // R10: partial mode, every shift, weights of both signs
        cfg_partial = 1'b1; cfg_thresh = 8'd250; cfg_after = 8'd128;
        cfg_rest = 8'd20;
        for (int sh = 0; sh < 4; sh++) begin
            cfg_atten_shift = sh[1:0];
            for (int w = -128; w <= 127; w += 9) begin
                settle("R10");
                make_fire("R10");
                cyc("R10", 1, w, 1, -5, 0);
                cyc("R10", 0, 0, 0, 0, 0);
            end
        end

        // R1: reset mid-refractory returns to rest and operational
        make_fire("R1");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pot = cfg_rest; m_ref = 0; m_fire = 0;
        compare("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule